// File: doc/BRIEF.md
# One-Time Clock Source Selector

This block decides, once per reset, which oscillator drives the system clock. After reset the system runs from the on-chip oscillator. The block holds that source enabled and keeps the clock multiplexer select at the on-chip code until the core issues a selection command. Each bit of the command vector names one external oscillation circuit. The first command to arrive is committed, and from then on only the chosen circuit stays enabled. Every other external circuit and the on-chip oscillator are switched off.

Separately, a stabilization timer runs on the on-chip oscillator clock from the moment reset is released. It holds `ready` low for a parameterized number of cycles, 256 by default. All pins are plain control and status levels. There is no data stream and no handshake.

Top module: `clksrc_picker`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `ready`=0, `locked`=0, `clk_sel`=0, `en_onchip`=1, `en_ext`=0.
- R2: `ready` goes high exactly WAIT_CYCLES rising clock edges after `rst_n` is released, and it stays high until the next reset.
- R3: Before any command is committed, `clk_sel` is 0 (the on-chip code), `en_onchip` is 1 and `en_ext` is all zeros.
- R4: A command bit `sel_cmd[i]` sampled high at a rising edge, with nothing yet committed, makes `clk_sel` equal i+1 and `locked` equal 1 after that edge.
- R5: After commitment, exactly one enable is high: `en_ext[i]` for the chosen source. `en_onchip` is 0.
- R6: Once `locked` is 1, any further command of any kind leaves `clk_sel` and the enables unchanged.
- R7: If several command bits are high at the same edge, the lowest index wins.
- R8: Reset clears the commitment, so that a new selection can be made after it.
- R9: Commands are accepted whether or not the stabilization wait has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | On-chip oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_cmd | input | NUM_EXT | One pulse bit per external source selection command |
| en_onchip | output | 1 | Enable for the on-chip oscillator |
| en_ext | output | NUM_EXT | Enables for the external oscillation circuits |
| clk_sel | output | SEL_W | Multiplexer select: 0 is on-chip, i+1 is external source i |
| locked | output | 1 | Sticky flag showing that a selection has been committed |
| ready | output | 1 | High once the stabilization wait is over |

## Verification
A command sampled at a rising edge is reflected in `clk_sel`, the enables and `locked` right after that edge, because one register stage lies between the command and those outputs. The bench therefore drives commands on the falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. `ready` is due exactly WAIT_CYCLES edges after reset release. The bench releases reset on a falling edge and reads `ready` after WAIT_CYCLES-1 edges, expecting it low. It reads again after WAIT_CYCLES edges, expecting it high, so an off-by-one in either direction is caught.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int unsigned CLKSRC_DEF_WAIT = 256;
  localparam int unsigned CLKSRC_DEF_EXT  = 2;

  typedef enum logic {
    TMR_COUNTING = 1'b0,
    TMR_DONE     = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/clksrc_stab_timer.sv
module clksrc_stab_timer
  import clksrc_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = CLKSRC_DEF_WAIT
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  tmr_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TMR_COUNTING;
      cnt   <= '0;
    end else if (state == TMR_COUNTING) begin
      if (cnt == LAST) begin
        state <= TMR_DONE;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign ready = (state == TMR_DONE);

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/clksrc_first_latch.sv
module clksrc_first_latch #(
  parameter int unsigned NUM_EXT = 2,
  parameter int unsigned SEL_W   = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] sel_cmd,
  output logic               locked,
  output logic [SEL_W-1:0]   code
);
  localparam int unsigned IDX_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1;

  logic             hit;
  logic [IDX_W-1:0] pick_idx;

  // lowest index wins: scan downward so the last match kept is the lowest
  always_comb begin
    hit      = |sel_cmd;
    pick_idx = '0;
    for (int i = NUM_EXT - 1; i >= 0; i--) begin
      if (sel_cmd[i]) pick_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      code   <= '0;
    end else if (!locked && hit) begin
      locked <= 1'b1;
      code   <= SEL_W'(pick_idx) + SEL_W'(1);
    end
  end

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(code)));

  // R7
  low_index_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && sel_cmd[0]) |=> (code == SEL_W'(1)));

  // R4
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && |sel_cmd) |=> locked);
endmodule

// File: rtl/clksrc_enable_dec.sv
module clksrc_enable_dec #(
  parameter int unsigned NUM_EXT = 2,
  parameter int unsigned SEL_W   = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               locked,
  input  logic [SEL_W-1:0]   code,
  output logic               en_onchip,
  output logic [NUM_EXT-1:0] en_ext,
  output logic [SEL_W-1:0]   clk_sel
);
  assign en_onchip = !locked;
  assign clk_sel   = locked ? code : '0;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_en
    assign en_ext[g] = locked && (code == SEL_W'(g + 1));
  end

  // R5
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({en_ext, en_onchip}) == 1);

  // R3
  onchip_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_onchip |-> (clk_sel == '0));
endmodule

// File: rtl/clksrc_picker.sv
module clksrc_picker
  import clksrc_pkg::*;
#(
  parameter int unsigned NUM_EXT     = CLKSRC_DEF_EXT,
  parameter int unsigned WAIT_CYCLES = CLKSRC_DEF_WAIT,
  parameter int unsigned SEL_W       = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] sel_cmd,
  output logic               en_onchip,
  output logic [NUM_EXT-1:0] en_ext,
  output logic [SEL_W-1:0]   clk_sel,
  output logic               locked,
  output logic               ready
);
  logic [SEL_W-1:0] code;

  clksrc_stab_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready)
  );

  clksrc_first_latch #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_cmd (sel_cmd),
    .locked  (locked),
    .code    (code)
  );

  clksrc_enable_dec #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (locked),
    .code      (code),
    .en_onchip (en_onchip),
    .en_ext    (en_ext),
    .clk_sel   (clk_sel)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!locked && !ready && en_onchip));
endmodule

// File: tb/clksrc_picker_bench.sv
`timescale 1ns/1ps
module clksrc_picker_bench;
  localparam int unsigned NUM_EXT = 2;
  localparam int unsigned WAIT    = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_EXT-1:0] sel_cmd = '0;
  logic en_onchip;
  logic [NUM_EXT-1:0] en_ext;
  logic [1:0] clk_sel;
  logic locked;
  logic ready;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clksrc_picker #(.NUM_EXT(NUM_EXT), .WAIT_CYCLES(WAIT)) u_clksrc_picker (
    .clk(clk), .rst_n(rst_n), .sel_cmd(sel_cmd), .en_onchip(en_onchip),
    .en_ext(en_ext), .clk_sel(clk_sel), .locked(locked), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NUM_EXT-1:0] v);
    sel_cmd = v;
    step(1);
    sel_cmd = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    step(2);
    check("R1 ready", int'(ready), 0);
    check("R1 locked", int'(locked), 0);
    check("R1 clk_sel", int'(clk_sel), 0);
    check("R1 en_onchip", int'(en_onchip), 1);
    check("R1 en_ext", int'(en_ext), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_wait;
    t_reset();
    step(WAIT - 1);
    check("R2 ready early", int'(ready), 0);
    check("R3 clk_sel idle", int'(clk_sel), 0);
    check("R3 en_onchip idle", int'(en_onchip), 1);
    check("R3 en_ext idle", int'(en_ext), 0);
    step(1);
    check("R2 ready due", int'(ready), 1);
    step(20);
    check("R2 ready held", int'(ready), 1);
  endtask

  task automatic t_pick_second;
    pulse(2'b10);
    check("R4 clk_sel", int'(clk_sel), 2);
    check("R4 locked", int'(locked), 1);
    check("R5 en_ext", int'(en_ext), 2);
    check("R5 en_onchip", int'(en_onchip), 0);
    pulse(2'b01);
    check("R6 clk_sel after later cmd", int'(clk_sel), 2);
    check("R6 en_ext after later cmd", int'(en_ext), 2);
    pulse(2'b11);
    check("R6 clk_sel after both", int'(clk_sel), 2);
    check("R6 en_onchip stays off", int'(en_onchip), 0);
  endtask

  task automatic t_both_during_wait;
    t_reset();
    check("R8 cleared after reset", int'(clk_sel), 0);
    step(3);
    pulse(2'b11);
    check("R9 ready low while picked", int'(ready), 0);
    check("R7 clk_sel both", int'(clk_sel), 1);
    check("R5 en_ext both", int'(en_ext), 1);
    check("R8 locked again", int'(locked), 1);
    pulse(2'b10);
    check("R6 second ignored", int'(clk_sel), 1);
    step(WAIT - 6);
    check("R2 ready edge-1", int'(ready), 0);
    step(1);
    check("R2 ready edge", int'(ready), 1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_wait();
    t_pick_second();
    t_both_during_wait();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule